// File: doc/BRIEF.md
# Atomic Byte Swap Execution Unit

This unit executes one family of atomic byte-exchange instructions. A 32-bit instruction word is offered with `instValid` while the unit is idle. If the word belongs to the family, the unit takes two operands from the register file. One is the base register, or the stack pointer when the base field is 31. The other is the low byte of the source register. The unit then issues exactly one atomic swap request to memory.

The request carries the address, the byte to store and four attribute flags: acquire, release, tag-checked and privileged. When memory returns the previous byte, the unit zero-extends it and writes it to the destination register.

Only one swap is in flight at a time. While one is outstanding, `busy` is high and offered instructions are ignored. Two conditions end an accepted word with a one-cycle indication instead of a memory access: the atomics feature is disabled, or a stack-pointer address is misaligned.

Top module: `swp_unit`

## Requirements
- R1: A word is in the family only if bits 31:30=00, 29:27=111, 26=0, 25:24=00, 21=1, 15=1, 14:12=000 and 11:10=00. Any other word causes no request, no indication and no change of `busy`.
- R2: If a family word is accepted while `featureEn` is 0, `undefInst` pulses for one cycle on the cycle after acceptance. No request is issued.
- R3: `memAcquire` is 1 only when bit 23 is 1 and the destination field (bits 4:0) is not 31.
- R4: `memRelease` equals bit 22 of the word, whatever the destination.
- R5: When the base field (bits 9:5) is 31, `memAddr` is `spValue` and `memTagChecked` is 0. Otherwise `memAddr` is the register named by bits 9:5 and `memTagChecked` is 1.
- R6: A stack-pointer address whose low 4 bits are not all zero makes `alignFault` pulse on the cycle after acceptance, with no request. A misaligned general-register base is issued normally.
- R7: `memWrByte` is the low 8 bits of the register named by bits 20:16.
- R8: On the cycle after `memRspValid`, `wbValid` is 1, `wbAddr` is bits 4:0 and `wbData` is the returned byte zero-extended to 32 bits.
- R9: If the destination field is 31, the request is still issued, but no write-back occurs.
- R10: `memPriv` is 1 exactly when `exLevel` is not 0.
- R11: `memReqValid` rises on the cycle after acceptance. It and all request fields hold steady until `memReqReady` is seen. `busy` stays high from acceptance until the write-back cycle, and instructions offered while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| featureEn | input | 1 | Atomics feature implemented |
| exLevel | input | 2 | Current exception level |
| spValue | input | 64 | Stack pointer value |
| instValid | input | 1 | Instruction word offered |
| instWord | input | 32 | Instruction word |
| busy | output | 1 | A swap is in progress |
| undefInst | output | 1 | Undefined-instruction pulse |
| alignFault | output | 1 | Stack alignment fault pulse |
| rdAddrBase | output | 5 | Register-read address for the base |
| rdDataBase | input | 64 | Base register value |
| rdAddrSrc | output | 5 | Register-read address for the source |
| rdSrcByte | input | 8 | Low byte of the source register |
| memReqValid | output | 1 | Swap request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memAddr | output | 64 | Swap address |
| memWrByte | output | 8 | Byte to store |
| memAcquire | output | 1 | Load side has acquire ordering |
| memRelease | output | 1 | Store side has release ordering |
| memTagChecked | output | 1 | Access is tag-checked |
| memPriv | output | 1 | Access is privileged |
| memRspValid | input | 1 | Old byte returned |
| memRspByte | input | 8 | Old byte |
| wbValid | output | 1 | Destination write strobe |
| wbAddr | output | 5 | Destination register |
| wbData | output | 32 | Zero-extended old byte |

## Verification
The assertions check several properties on every cycle:
- A stalled request stays steady.
- A request exists only while busy.
- Requests without tag checking always carry aligned addresses.
- Write-backs never target register 31, always follow a response and never have nonzero upper bits.
- At most one completion indication is active at a time.

Only the bench's scenarios can show that the flag values track the word's fields and the exception level. The same holds for picking the stack pointer over the register file, for the fault and undefined paths suppressing requests, and for an ignored word leaving the unit idle.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int INST_W = 32;
  localparam int REG_AW = 5;
  localparam int BYTE_W = 8;
  localparam int WB_W   = 32;
  localparam logic [REG_AW-1:0] ZERO_REG = '1;

  typedef struct packed {
    logic capReq;   // latch request fields from decode and register read
    logic capRsp;   // latch returned byte into write-back stage
  } swp_strobe_t;

  typedef struct packed {
    logic isFamily;
    logic spMisaligned;
  } swp_status_t;

  typedef struct packed {
    logic              acq;
    logic              rel;
    logic [REG_AW-1:0] src;
    logic [REG_AW-1:0] base;
    logic [REG_AW-1:0] dst;
  } swp_fields_t;

  function automatic logic isFamilyWord(input logic [INST_W-1:0] w);
    return (w[31:30] == 2'b00) && (w[29:27] == 3'b111) && (w[26] == 1'b0) &&
           (w[25:24] == 2'b00) && (w[21] == 1'b1) && (w[15] == 1'b1) &&
           (w[14:12] == 3'b000) && (w[11:10] == 2'b00);
  endfunction

  function automatic swp_fields_t splitFields(input logic [INST_W-1:0] w);
    swp_fields_t f;
    f.acq  = w[23];
    f.rel  = w[22];
    f.src  = w[20:16];
    f.base = w[9:5];
    f.dst  = w[4:0];
    return f;
  endfunction
endpackage

// File: rtl/swp_datapath.sv
module swp_datapath
  import swp_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int ALIGN_BITS = 4,
  parameter int EL_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INST_W-1:0] instWord,
  input  logic [XLEN-1:0]   spValue,
  input  logic [EL_W-1:0]   exLevel,
  input  logic [XLEN-1:0]   rdDataBase,
  input  logic [BYTE_W-1:0] rdSrcByte,
  input  logic [BYTE_W-1:0] memRspByte,
  input  swp_strobe_t       strb,
  output swp_status_t       status,
  output logic [REG_AW-1:0] rdAddrBase,
  output logic [REG_AW-1:0] rdAddrSrc,
  output logic [XLEN-1:0]   memAddr,
  output logic [BYTE_W-1:0] memWrByte,
  output logic              memAcquire,
  output logic              memRelease,
  output logic              memTagChecked,
  output logic              memPriv,
  output logic              wbValid,
  output logic [REG_AW-1:0] wbAddr,
  output logic [WB_W-1:0]   wbData
);
  localparam int PAD_W = WB_W - BYTE_W;

  swp_fields_t      fld;
  logic             baseIsSp;
  logic [XLEN-1:0]  addrSel;
  logic [REG_AW-1:0] dstQ;

  always_comb begin
    fld        = splitFields(instWord);
    baseIsSp   = (fld.base == ZERO_REG);
    addrSel    = baseIsSp ? spValue : rdDataBase;
    rdAddrBase = fld.base;
    rdAddrSrc  = fld.src;
    status.isFamily     = isFamilyWord(instWord);
    status.spMisaligned = baseIsSp && (spValue[ALIGN_BITS-1:0] != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr       <= '0;
      memWrByte     <= '0;
      memAcquire    <= 1'b0;
      memRelease    <= 1'b0;
      memTagChecked <= 1'b0;
      memPriv       <= 1'b0;
      dstQ          <= '0;
    end else if (strb.capReq) begin
      memAddr       <= addrSel;
      memWrByte     <= rdSrcByte;
      memAcquire    <= fld.acq && (fld.dst != ZERO_REG);
      memRelease    <= fld.rel;
      memTagChecked <= !baseIsSp;
      memPriv       <= (exLevel != '0);
      dstQ          <= fld.dst;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      wbAddr  <= '0;
      wbData  <= '0;
    end else begin
      wbValid <= strb.capRsp && (dstQ != ZERO_REG);
      if (strb.capRsp) begin
        wbAddr <= dstQ;
        wbData <= {{PAD_W{1'b0}}, memRspByte};
      end
    end
  end
endmodule

// File: rtl/swp_ctrl.sv
module swp_ctrl
  import swp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic        featureEn,
  input  swp_status_t status,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output swp_strobe_t strb,
  output logic        busy,
  output logic        memReqValid,
  output logic        undefInst,
  output logic        alignFault
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} swp_state_e;
  swp_state_e state, stateNext;
  logic accept, goUndef, goFault;

  always_comb begin
    accept     = (state == ST_IDLE) && instValid && status.isFamily;
    goUndef    = accept && !featureEn;
    goFault    = accept && featureEn && status.spMisaligned;
    strb.capReq = accept && featureEn && !status.spMisaligned;
    strb.capRsp = (state == ST_WAIT) && memRspValid;
    stateNext  = state;
    unique case (state)
      ST_IDLE: if (strb.capReq) stateNext = ST_REQ;
      ST_REQ:  if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (memRspValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      undefInst  <= 1'b0;
      alignFault <= 1'b0;
      busy       <= 1'b0;
    end else begin
      state      <= stateNext;
      undefInst  <= goUndef;
      alignFault <= goFault;
      // busy drops in the write-back cycle
      busy       <= (stateNext != ST_IDLE);
    end
  end

  assign memReqValid = (state == ST_REQ);
endmodule

// File: rtl/swp_unit.sv
module swp_unit
  import swp_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int ALIGN_BITS = 4,
  parameter int EL_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              featureEn,
  input  logic [EL_W-1:0]   exLevel,
  input  logic [XLEN-1:0]   spValue,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  output logic              busy,
  output logic              undefInst,
  output logic              alignFault,
  output logic [REG_AW-1:0] rdAddrBase,
  input  logic [XLEN-1:0]   rdDataBase,
  output logic [REG_AW-1:0] rdAddrSrc,
  input  logic [BYTE_W-1:0] rdSrcByte,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [XLEN-1:0]   memAddr,
  output logic [BYTE_W-1:0] memWrByte,
  output logic              memAcquire,
  output logic              memRelease,
  output logic              memTagChecked,
  output logic              memPriv,
  input  logic              memRspValid,
  input  logic [BYTE_W-1:0] memRspByte,
  output logic              wbValid,
  output logic [REG_AW-1:0] wbAddr,
  output logic [WB_W-1:0]   wbData
);
  swp_strobe_t strb;
  swp_status_t status;

  swp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .featureEn(featureEn),
    .status(status), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .strb(strb), .busy(busy), .memReqValid(memReqValid),
    .undefInst(undefInst), .alignFault(alignFault)
  );

  swp_datapath #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS), .EL_W(EL_W)) i_dp (
    .clk(clk), .rstN(rstN), .instWord(instWord), .spValue(spValue),
    .exLevel(exLevel), .rdDataBase(rdDataBase), .rdSrcByte(rdSrcByte),
    .memRspByte(memRspByte), .strb(strb), .status(status),
    .rdAddrBase(rdAddrBase), .rdAddrSrc(rdAddrSrc), .memAddr(memAddr),
    .memWrByte(memWrByte), .memAcquire(memAcquire), .memRelease(memRelease),
    .memTagChecked(memTagChecked), .memPriv(memPriv), .wbValid(wbValid),
    .wbAddr(wbAddr), .wbData(wbData)
  );
endmodule

// File: rtl/swp_unit_chk.sv
module swp_unit_chk #(
  parameter int XLEN       = 64,
  parameter int ALIGN_BITS = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            undefInst,
  input logic            alignFault,
  input logic            memReqValid,
  input logic            memReqReady,
  input logic [XLEN-1:0] memAddr,
  input logic [7:0]      memWrByte,
  input logic            memTagChecked,
  input logic            memRspValid,
  input logic            wbValid,
  input logic [4:0]      wbAddr,
  input logic [31:0]     wbData
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memAddr) && $stable(memWrByte)); // R11
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy); // R11
  AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memTagChecked |-> memAddr[ALIGN_BITS-1:0] == '0); // R6
  AST_NO_ZR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> wbAddr != 5'd31); // R9
  AST_WB_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> wbData[31:8] == '0); // R8
  AST_WB_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(memRspValid)); // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({undefInst, alignFault, wbValid, memReqValid})); // R2
endmodule

bind swp_unit swp_unit_chk #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .undefInst(undefInst),
  .alignFault(alignFault), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memAddr(memAddr), .memWrByte(memWrByte), .memTagChecked(memTagChecked),
  .memRspValid(memRspValid), .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData)
);

// File: tb/test_swp_unit.sv
`timescale 1ns/1ps
module test_swp_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        featureEn = 1'b1;
  logic [1:0]  exLevel = 2'd0;
  logic [63:0] spValue = 64'h0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = 32'h0;
  logic        busy, undefInst, alignFault;
  logic [4:0]  rdAddrBase, rdAddrSrc;
  logic [63:0] rdDataBase;
  logic [7:0]  rdSrcByte;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [63:0] memAddr;
  logic [7:0]  memWrByte;
  logic        memAcquire, memRelease, memTagChecked, memPriv;
  logic        memRspValid = 1'b0;
  logic [7:0]  memRspByte = 8'h0;
  logic        wbValid;
  logic [4:0]  wbAddr;
  logic [31:0] wbData;

  logic [63:0] regs [32];
  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  assign rdDataBase = regs[rdAddrBase];
  assign rdSrcByte  = regs[rdAddrSrc][7:0];

  swp_unit i_swp_unit (.*);

  function automatic logic [31:0] mkWord(bit a, bit r, logic [4:0] rs, logic [4:0] rn, logic [4:0] rt);
    return 32'h3820_8000 | (32'(a) << 23) | (32'(r) << 22) | (32'(rs) << 16) | (32'(rn) << 5) | 32'(rt);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic offer(logic [31:0] w);
    instWord = w; instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
  endtask

  // full swap with a one-cycle stall and an ignored word while busy
  task automatic runSwap(bit a, bit r, logic [4:0] rs, logic [4:0] rn, logic [4:0] rt,
                         logic [63:0] expAddr, logic [1:0] el, logic [7:0] oldByte);
    logic [31:0] w;
    w = mkWord(a, r, rs, rn, rt);
    exLevel = el;
    offer(w);
    chk("R11 req valid", memReqValid, 1);
    chk("R11 busy", busy, 1);
    chk("R5 addr", memAddr, expAddr);
    chk("R5 tag", memTagChecked, (rn != 5'd31));
    chk("R7 store byte", memWrByte, regs[rs][7:0]);
    chk("R3 acquire", memAcquire, (a && rt != 5'd31));
    chk("R4 release", memRelease, r);
    chk("R10 priv", memPriv, (el != 2'd0));
    offer(mkWord(1, 1, 5'd1, 5'd2, 5'd3)); // ignored while busy
    chk("R11 held", memReqValid, 1);
    chk("R11 held addr", memAddr, expAddr);
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    chk("R11 req dropped", memReqValid, 0);
    memRspByte = oldByte; memRspValid = 1'b1;
    @(negedge clk);
    memRspValid = 1'b0;
    if (rt == 5'd31) begin
      chk("R9 no wb", wbValid, 0);
    end else begin
      chk("R8 wb valid", wbValid, 1);
      chk("R8 wb addr", wbAddr, rt);
      chk("R8 wb data", wbData, {24'h0, oldByte});
    end
    chk("R11 busy cleared", busy, 0);
    @(negedge clk);
    chk("R11 no second req", memReqValid, 0);
    chk("R11 stays idle", busy, 0);
  endtask

  task automatic testNonFamily();
    offer(mkWord(0, 0, 5'd1, 5'd2, 5'd3) & ~32'h0000_8000);
    chk("R1 no req", memReqValid, 0);
    chk("R1 not busy", busy, 0);
    chk("R1 no undef", undefInst, 0);
    offer(mkWord(0, 0, 5'd1, 5'd2, 5'd3) | 32'h4000_0000);
    chk("R1 size bits", memReqValid | busy, 0);
  endtask

  task automatic testUndef();
    featureEn = 1'b0;
    offer(mkWord(1, 1, 5'd1, 5'd2, 5'd3));
    chk("R2 undef", undefInst, 1);
    chk("R2 no req", memReqValid, 0);
    @(negedge clk);
    chk("R2 pulse", undefInst, 0);
    featureEn = 1'b1;
  endtask

  task automatic testAlign();
    spValue = 64'h0000_1000_0000_2008;
    offer(mkWord(0, 0, 5'd1, 5'd31, 5'd3));
    chk("R6 fault", alignFault, 1);
    chk("R6 no req", memReqValid, 0);
    @(negedge clk);
    chk("R6 pulse", alignFault, 0);
    chk("R6 idle", busy, 0);
    spValue = 64'h0000_1000_0000_2000;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'hA5A5_0000_0000_0000 | 64'(i * 8'h11 + 3);
    regs[2] = 64'h0000_0000_DEAD_BEE3; // misaligned general base
    spValue = 64'h0000_1000_0000_2000;
    repeat (3) @(negedge clk);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset req", memReqValid, 0);
    chk("R8 reset wb", wbValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    testNonFamily();
    testUndef();
    testAlign();
    runSwap(0, 0, 5'd4, 5'd2, 5'd7, regs[2], 2'd0, 8'h9C);
    runSwap(1, 0, 5'd5, 5'd31, 5'd8, spValue, 2'd1, 8'hFF);
    runSwap(1, 1, 5'd6, 5'd9, 5'd31, regs[9], 2'd2, 8'h11);
    runSwap(0, 1, 5'd31, 5'd10, 5'd0, regs[10], 2'd3, 8'h80);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule